// File: doc/BRIEF.md
# I2C Target Register File

This block lets a two-wire serial bus controller read and write a small bank of control registers. The serial clock and data lines are brought into the system clock domain through flop synchronizers. Bus events are decoded from their sampled edges, and the block pulls the data line low only through an output-enable signal. It answers only to the fixed 7-bit target address 0x63.

A write transfer has three bytes: the address byte with R/W = 0, then a register pointer, then a data byte. A read transfer has the address byte with R/W = 1. It returns the byte at the pointer that was last written. The usual sequence is a pointer write, a repeated START, and then the read.

Each register comes out of reset with its own value, and its unused bits are forced to zero. A read of the flags location returns the status supplied from outside and emits a one-cycle clear pulse back to that source. An external mode-clear input zeroes the two mode bits of the enable register.

Top module: `i2c_rf_top`

## Requirements
- R1: After reset the registers read back as follows: 0x0A = 0x00, 0x08 = 0x52, 0x09 = 0x0F, 0x01 = 0x80, 0x06 = 0x00 and 0x00 = 0x00. The data-line enable is low.
- R2: The block acknowledges an address byte whose upper seven bits equal 0x63 by pulling SDA low during the 9th clock. For any other address it leaves SDA released and ignores every byte until the next START or STOP.
- R3: In a write, the second byte sets the register pointer and the third byte is stored at the pointer. The block acknowledges every byte it receives, and a stored value appears on the matching register output port.
- R4: In a read, the block shifts out the byte at the current pointer MSB first and releases SDA during the 9th clock. The pointer stays unchanged between transfers.
- R5: A repeated START has the same effect as a first START and begins a new address byte.
- R6: Unused bits are masked on write and read as zero. The masks are 0x0A: 0xF3, 0x0B: 0x3F, 0x08: 0x7F, 0x09: 0x7F, 0x01: 0x9C and 0x06: 0x3F.
- R7: Location 0x00 is read-only and always returns the revision parameter (0x00 by default). Writes to it are acknowledged and have no effect.
- R8: Writes to an unmapped location are acknowledged and change no register. Reads from an unmapped location return 0x00.
- R9: A read of 0x0B returns the status input masked to bits 5:0. Loading that byte for transmit raises the clear output for exactly one cycle. Reads of other locations produce no clear pulse.
- R10: While the mode-clear input is high, bits 1:0 of register 0x0A are held at zero, and this takes priority over a bus write in the same cycle. The other bits of that register are unaffected.
- R11: The data-line enable changes only while the sampled SCL is low, except for release at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| status_i | input | 8 | Status bits returned at location 0x0B |
| mode_clr_i | input | 1 | Clears the mode bits of register 0x0A |
| status_clr_o | output | 1 | One-cycle pulse when the 0x0B byte is loaded for transmit |
| en_reg_o | output | 8 | Register 0x0A |
| feat_reg_o | output | 8 | Register 0x08 |
| cur_reg_o | output | 8 | Register 0x09 |
| mon_reg_o | output | 8 | Register 0x01 |
| ramp_reg_o | output | 8 | Register 0x06 |

## Verification
The bench builds the block with its default parameters: target address 0x63, two synchronizer stages and revision 0x00. That is the configuration in which the register map and the masks are fixed. It uses a serial half-period of twelve system clocks, which is longer than the synchronizer and edge-detect latency. This lets it see the acknowledge appear and disappear inside the low phase of SCL, and it lets a mismatched address, a repeated START and a bare read without a pointer write all be driven against the real event decoder. Holding the mode-clear input across a complete write exercises the priority rule on the exact cycle the store happens.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    localparam logic [7:0] A_REV  = 8'h00;
    localparam logic [7:0] A_MON  = 8'h01;
    localparam logic [7:0] A_RAMP = 8'h06;
    localparam logic [7:0] A_FEAT = 8'h08;
    localparam logic [7:0] A_CUR  = 8'h09;
    localparam logic [7:0] A_EN   = 8'h0A;
    localparam logic [7:0] A_STAT = 8'h0B;

    localparam logic [7:0] M_EN   = 8'hF3;
    localparam logic [7:0] M_STAT = 8'h3F;
    localparam logic [7:0] M_FEAT = 8'h7F;
    localparam logic [7:0] M_CUR  = 8'h7F;
    localparam logic [7:0] M_MON  = 8'h9C;
    localparam logic [7:0] M_RAMP = 8'h3F;

    localparam logic [7:0] RV_EN   = 8'h00;
    localparam logic [7:0] RV_FEAT = 8'h52;
    localparam logic [7:0] RV_CUR  = 8'h0F;
    localparam logic [7:0] RV_MON  = 8'h80;
    localparam logic [7:0] RV_RAMP = 8'h00;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ACK_A, S_REG, S_ACK_R,
        S_WDAT, S_ACK_W, S_READ, S_RACK, S_SKIP
    } bus_st_e;

    typedef struct packed {
        bus_st_e     st;
        logic [3:0]  cnt;
        logic [7:0]  sr;
        logic [7:0]  ptr;
        logic        oe;
        logic        rw;
        logic        nack;
        logic        scl_p;
        logic        sda_p;
    } bus_t;

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] feat;
        logic [7:0] cur;
        logic [7:0] mon;
        logic [7:0] ramp;
        logic       clr;
    } regs_t;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '1;
        else        stg_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '1;
            else        stg_q[g] <= stg_q[g-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rf_bus.sv
module i2c_rf_bus
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h63
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [7:0] rdata_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wdata_o,
    output logic [7:0] ptr_o,
    output logic       ld_o
);
    bus_t st_d, st_q;
    logic rise, fall, sta, sto;
    logic wr_en, ld;

    assign rise = scl_i & ~st_q.scl_p;
    assign fall = ~scl_i & st_q.scl_p;
    assign sta  = scl_i & st_q.scl_p & st_q.sda_p & ~sda_i;
    assign sto  = scl_i & st_q.scl_p & ~st_q.sda_p & sda_i;

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        ld         = 1'b0;
        st_d.scl_p = scl_i;
        st_d.sda_p = sda_i;
        if (sto) begin
            st_d.st = S_IDLE;
            st_d.oe = 1'b0;
        end else if (sta) begin
            st_d.st  = S_ADDR;
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else begin
            case (st_q.st)
                S_ADDR, S_REG, S_WDAT: begin
                    if (rise) begin
                        st_d.sr  = {st_q.sr[6:0], sda_i};
                        st_d.cnt = st_q.cnt + 4'd1;
                    end else if (fall && st_q.cnt == 4'd8) begin
                        st_d.cnt = '0;
                        if (st_q.st == S_ADDR) begin
                            if (st_q.sr[7:1] == TGT_ADDR) begin
                                st_d.oe = 1'b1;
                                st_d.rw = st_q.sr[0];
                                st_d.st = S_ACK_A;
                            end else begin
                                st_d.st = S_SKIP;
                            end
                        end else if (st_q.st == S_REG) begin
                            st_d.ptr = st_q.sr;
                            st_d.oe  = 1'b1;
                            st_d.st  = S_ACK_R;
                        end else begin
                            wr_en   = 1'b1;
                            st_d.oe = 1'b1;
                            st_d.st = S_ACK_W;
                        end
                    end
                end
                S_ACK_A: begin
                    if (fall) begin
                        if (st_q.rw) begin
                            ld       = 1'b1;
                            st_d.sr  = rdata_i;
                            st_d.oe  = ~rdata_i[7];
                            st_d.cnt = '0;
                            st_d.st  = S_READ;
                        end else begin
                            st_d.oe = 1'b0;
                            st_d.st = S_REG;
                        end
                    end
                end
                S_ACK_R, S_ACK_W: begin
                    if (fall) begin
                        st_d.oe = 1'b0;
                        st_d.st = S_WDAT;
                    end
                end
                S_READ: begin
                    if (fall) begin
                        if (st_q.cnt == 4'd7) begin
                            st_d.oe  = 1'b0;
                            st_d.cnt = '0;
                            st_d.st  = S_RACK;
                        end else begin
                            st_d.cnt = st_q.cnt + 4'd1;
                            st_d.sr  = {st_q.sr[6:0], 1'b0};
                            st_d.oe  = ~st_q.sr[6];
                        end
                    end
                end
                S_RACK: begin
                    if (rise) begin
                        st_d.nack = sda_i;
                    end else if (fall) begin
                        if (st_q.nack) begin
                            st_d.st = S_SKIP;
                        end else begin
                            ld       = 1'b1;
                            st_d.sr  = rdata_i;
                            st_d.oe  = ~rdata_i[7];
                            st_d.cnt = '0;
                            st_d.st  = S_READ;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: S_IDLE, cnt: '0, sr: '0, ptr: '0, oe: 1'b0,
                      rw: 1'b0, nack: 1'b1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o = st_q.oe;
    assign wr_en_o  = wr_en;
    assign wdata_o  = st_q.sr;
    assign ptr_o    = st_q.ptr;
    assign ld_o     = ld;

    // R11: the data line is only switched during the low phase of SCL
    p_oe_quiet_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && st_q.scl_p && !sta && !sto) |=> $stable(st_q.oe));

    // R3: a store strobe lasts one cycle per received data byte
    p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: the line is released in the controller's acknowledge slot
    p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == S_RACK) |-> !st_q.oe);
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter logic [7:0] REV_ID = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] ptr_i,
    input  logic [7:0] wdata_i,
    input  logic       ld_i,
    input  logic [7:0] status_i,
    input  logic       mode_clr_i,
    output logic [7:0] rdata_o,
    output logic       clr_o,
    output logic [7:0] en_o,
    output logic [7:0] feat_o,
    output logic [7:0] cur_o,
    output logic [7:0] mon_o,
    output logic [7:0] ramp_o
);
    regs_t rg_d, rg_q;

    always_comb begin
        rg_d     = rg_q;
        rg_d.clr = ld_i && (ptr_i == A_STAT);
        if (wr_en_i) begin
            case (ptr_i)
                A_EN:    rg_d.en   = wdata_i & M_EN;
                A_FEAT:  rg_d.feat = wdata_i & M_FEAT;
                A_CUR:   rg_d.cur  = wdata_i & M_CUR;
                A_MON:   rg_d.mon  = wdata_i & M_MON;
                A_RAMP:  rg_d.ramp = wdata_i & M_RAMP;
                default: ;
            endcase
        end
        if (mode_clr_i) rg_d.en[1:0] = 2'b00;
    end

    always_comb begin
        case (ptr_i)
            A_REV:   rdata_o = REV_ID;
            A_MON:   rdata_o = rg_q.mon;
            A_RAMP:  rdata_o = rg_q.ramp;
            A_FEAT:  rdata_o = rg_q.feat;
            A_CUR:   rdata_o = rg_q.cur;
            A_EN:    rdata_o = rg_q.en;
            A_STAT:  rdata_o = status_i & M_STAT;
            default: rdata_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{en: RV_EN, feat: RV_FEAT, cur: RV_CUR, mon: RV_MON,
                      ramp: RV_RAMP, clr: 1'b0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign clr_o  = rg_q.clr;
    assign en_o   = rg_q.en;
    assign feat_o = rg_q.feat;
    assign cur_o  = rg_q.cur;
    assign mon_o  = rg_q.mon;
    assign ramp_o = rg_q.ramp;

    // R10: mode clear wins over any store in the same cycle
    p_mode_clr_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr_i |=> (rg_q.en[1:0] == 2'b00));

    // R9: the status clear is a single-cycle pulse
    p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.clr |=> !rg_q.clr);
endmodule

// File: rtl/i2c_rf_top.sv
module i2c_rf_top #(
    parameter logic [6:0] TGT_ADDR    = 7'h63,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] REV_ID      = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [7:0] status_i,
    input  logic       mode_clr_i,
    output logic       status_clr_o,
    output logic [7:0] en_reg_o,
    output logic [7:0] feat_reg_o,
    output logic [7:0] cur_reg_o,
    output logic [7:0] mon_reg_o,
    output logic [7:0] ramp_reg_o
);
    logic [1:0] line_s;
    logic       wr_en, ld;
    logic [7:0] wdata, ptr, rdata;

    i2c_rf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
    );

    i2c_rf_bus #(.TGT_ADDR(TGT_ADDR)) u_bus (
        .clk(clk), .rst_n(rst_n), .scl_i(line_s[1]), .sda_i(line_s[0]),
        .rdata_i(rdata), .sda_oe_o(sda_oe_o), .wr_en_o(wr_en),
        .wdata_o(wdata), .ptr_o(ptr), .ld_o(ld)
    );

    i2c_rf_regs #(.REV_ID(REV_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .ptr_i(ptr),
        .wdata_i(wdata), .ld_i(ld), .status_i(status_i),
        .mode_clr_i(mode_clr_i), .rdata_o(rdata), .clr_o(status_clr_o),
        .en_o(en_reg_o), .feat_o(feat_reg_o), .cur_o(cur_reg_o),
        .mon_o(mon_reg_o), .ramp_o(ramp_reg_o)
    );
endmodule

// File: tb/i2c_rf_top_tb_top.sv
module i2c_rf_top_tb_top;
    localparam int CLK_NS = 10;
    localparam int H = 12;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe_o, status_clr_o, mode_clr_i = 1'b0;
    logic [7:0] status_i = 8'h00;
    logic [7:0] en_reg_o, feat_reg_o, cur_reg_o, mon_reg_o, ramp_reg_o;

    int nvec = 0, nfail = 0, nclr = 0, nviol = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_q [$];

    always #(CLK_NS/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe_o;

    i2c_rf_top dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .status_i(status_i), .mode_clr_i(mode_clr_i),
        .status_clr_o(status_clr_o), .en_reg_o(en_reg_o),
        .feat_reg_o(feat_reg_o), .cur_reg_o(cur_reg_o),
        .mon_reg_o(mon_reg_o), .ramp_reg_o(ramp_reg_o)
    );

    logic scl_prev = 1'b1;
    logic oe_prev  = 1'b0;
    always @(posedge clk) begin
        if (status_clr_o) nclr++;
        // R11 bench view: enable may not move while SCL stays high
        if (rst_n && scl_m && scl_prev && (sda_oe_o !== oe_prev)) nviol++;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe_o;
    end

    task automatic ck(input bit ok, input string tag, input logic [7:0] act,
                      input logic [7:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            wait (obs_q.size() != 0);
            begin
                logic [7:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                ck(o === e, t, o, e);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        wt(Q); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H); scl_m = 1'b0;
    endtask

    task automatic m_stop;
        wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic m_bit(input logic b, output logic r);
        wt(Q); sda_m = b; wt(H - Q); scl_m = 1'b1;
        wt(Q); r = sda_line; wt(H - Q); scl_m = 1'b0;
    endtask

    task automatic m_byte(input logic [7:0] b, output logic ackb);
        logic d;
        for (int i = 7; i >= 0; i--) m_bit(b[i], d);
        m_bit(1'b1, ackb);
    endtask

    task automatic m_rbyte(input logic mack, output logic [7:0] v, output logic slot);
        for (int i = 7; i >= 0; i--) m_bit(1'b1, v[i]);
        m_bit(mack, slot);
    endtask

    task automatic wr(input logic [7:0] ra, input logic [7:0] val, input string tag);
        logic a;
        m_start;
        m_byte(8'hC6, a); ck(a == 1'b0, {tag, " R2 addr ack"}, {7'b0, a}, 8'h00);
        m_byte(ra, a);    ck(a == 1'b0, {tag, " R3 ptr ack"}, {7'b0, a}, 8'h00);
        m_byte(val, a);   ck(a == 1'b0, {tag, " R3 data ack"}, {7'b0, a}, 8'h00);
        m_stop;
    endtask

    task automatic rd(input logic [7:0] ra, input logic [7:0] exp, input string tag);
        logic a, slot;
        logic [7:0] v;
        m_start;
        m_byte(8'hC6, a); ck(a == 1'b0, {tag, " R2 addr ack"}, {7'b0, a}, 8'h00);
        m_byte(ra, a);    ck(a == 1'b0, {tag, " R3 ptr ack"}, {7'b0, a}, 8'h00);
        m_start;          // R5 repeated start
        m_byte(8'hC7, a); ck(a == 1'b0, {tag, " R5 read addr ack"}, {7'b0, a}, 8'h00);
        m_rbyte(1'b1, v, slot);
        ck(slot == 1'b1, {tag, " R4 released in 9th clock"}, {7'b0, slot}, 8'h01);
        m_stop;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        obs_q.push_back(v);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
        summary;
        $finish;
    end

    initial begin
        logic a, slot;
        logic [7:0] v;
        int c0;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1 reset state at the ports
        ck(sda_oe_o == 1'b0, "R1 sda enable idle", {7'b0, sda_oe_o}, 8'h00);
        ck(en_reg_o == 8'h00, "R1 enable port", en_reg_o, 8'h00);
        ck(feat_reg_o == 8'h52, "R1 feature port", feat_reg_o, 8'h52);
        ck(cur_reg_o == 8'h0F, "R1 current port", cur_reg_o, 8'h0F);
        ck(mon_reg_o == 8'h80, "R1 monitor port", mon_reg_o, 8'h80);
        ck(ramp_reg_o == 8'h00, "R1 ramp port", ramp_reg_o, 8'h00);
        // R1 reset values over the bus
        rd(8'h0A, 8'h00, "R1 read 0x0A");
        rd(8'h08, 8'h52, "R1 read 0x08");
        rd(8'h09, 8'h0F, "R1 read 0x09");
        rd(8'h01, 8'h80, "R1 read 0x01");
        rd(8'h06, 8'h00, "R1 read 0x06");
        rd(8'h00, 8'h00, "R1 read 0x00");

        // R3 plain store
        wr(8'h08, 8'h35, "R3 write 0x08");
        ck(feat_reg_o == 8'h35, "R3 feature port", feat_reg_o, 8'h35);
        rd(8'h08, 8'h35, "R3 readback 0x08");

        // R6 masks
        wr(8'h09, 8'hFF, "R6 0x09");  rd(8'h09, 8'h7F, "R6 readback 0x09");
        wr(8'h01, 8'hFF, "R6 0x01");  rd(8'h01, 8'h9C, "R6 readback 0x01");
        wr(8'h06, 8'hFF, "R6 0x06");  rd(8'h06, 8'h3F, "R6 readback 0x06");
        wr(8'h0A, 8'hFF, "R6 0x0A");
        ck(en_reg_o == 8'hF3, "R6 enable port", en_reg_o, 8'hF3);

        // R2 foreign address ignored
        m_start;
        m_byte(8'hC4, a); ck(a == 1'b1, "R2 no ack for 0x62", {7'b0, a}, 8'h01);
        m_byte(8'h0A, a); ck(a == 1'b1, "R2 silent after mismatch", {7'b0, a}, 8'h01);
        m_byte(8'h00, a);
        m_stop;
        ck(en_reg_o == 8'hF3, "R2 enable untouched", en_reg_o, 8'hF3);

        // R7 revision read-only
        wr(8'h00, 8'h5A, "R7 write 0x00");
        rd(8'h00, 8'h00, "R7 readback 0x00");

        // R8 unmapped location
        wr(8'h20, 8'hAA, "R8 write 0x20");
        ck(en_reg_o == 8'hF3 && feat_reg_o == 8'h35 && cur_reg_o == 8'h7F,
           "R8 no register changed", en_reg_o, 8'hF3);
        rd(8'h20, 8'h00, "R8 readback 0x20");

        // R9 status read and clear pulse
        status_i = 8'hE5;
        c0 = nclr;
        rd(8'h0B, 8'h25, "R9 read 0x0B");
        ck(nclr - c0 == 1, "R9 one clear pulse", 8'(nclr - c0), 8'h01);
        c0 = nclr;
        rd(8'h08, 8'h35, "R9 read 0x08");
        ck(nclr - c0 == 0, "R9 no pulse elsewhere", 8'(nclr - c0), 8'h00);

        // R4 bare read keeps the last pointer (0x08)
        m_start;
        m_byte(8'hC7, a); ck(a == 1'b0, "R4 bare read ack", {7'b0, a}, 8'h00);
        m_rbyte(1'b1, v, slot);
        m_stop;
        exp_q.push_back(8'h35); tag_q.push_back("R4 bare read data"); obs_q.push_back(v);

        // R10 mode clear
        wr(8'h0A, 8'h13, "R10 set 0x0A");
        ck(en_reg_o == 8'h13, "R10 before clear", en_reg_o, 8'h13);
        @(negedge clk); mode_clr_i = 1'b1; @(negedge clk); mode_clr_i = 1'b0;
        wt(2);
        ck(en_reg_o == 8'h10, "R10 clear alone", en_reg_o, 8'h10);
        mode_clr_i = 1'b1;
        wr(8'h0A, 8'h33, "R10 write under clear");
        mode_clr_i = 1'b0;
        wt(2);
        ck(en_reg_o == 8'h30, "R10 priority over write", en_reg_o, 8'h30);

        ck(nviol == 0, "R11 enable moved with SCL high", 8'(nviol), 8'h00);
        wait (obs_q.size() == 0);
        wt(4);
        summary;
        $finish;
    end
endmodule